// File: doc/BRIEF.md
# Monochrome Adapter Mode, Configuration and Status Registers

This block holds the host-visible control state of a monochrome graphics adapter. A host writes a mode byte and a configuration byte. The configuration byte works as a safety interlock. Two bits of the mode byte can be turned on only while the matching configuration enable is set:

- the graphics-mode bit;
- the upper-display-page bit.

Either of these bits can be turned off at any time. All other mode bits are stored exactly as written. Bit 5 of the stored mode drives the blink enable, and the upper-page bit selects a display base address.

The block also assembles a read-only status byte. It is built from two retrace inputs that come from an external timing generator. The byte contains:

- the horizontal retrace flag;
- an inverted vertical retrace flag;
- a fixed identity pattern;
- a derived video-activity flag.

The retrace inputs are sampled once per clock. The status byte follows them with one register of delay. Both write strobes are single-cycle and take effect on the next rising clock edge.

Top module: `mono_mode_status`

## Requirements
- R1: While reset is asserted and after it is released with no writes, the mode byte reads 0x0A, the configuration byte reads 0x00, the blink enable is 0 and the page base is 0.
- R2: A mode write sets bit 1 (graphics) only if bit 0 of the configuration byte held before that clock edge is 1, or if bit 1 is already set.
- R3: A mode write with bit 1 clear always clears bit 1, and a mode write with bit 7 clear always clears bit 7, whatever the configuration byte holds.
- R4: A mode write sets bit 7 (upper page) only if bit 1 of the configuration byte held before that clock edge is 1, or if bit 7 is already set.
- R5: On a mode write, mode bits 0, 2, 3, 4, 5 and 6 take the written value unchanged. The blink enable output equals stored mode bit 5.
- R6: The page base output is 0x8000 when stored mode bit 7 is 1 and 0x0000 otherwise.
- R7: A configuration write stores all 8 bits and reads back unchanged after the next edge. Configuration bits 7:2 have no effect on the mode gating.
- R8: Status bit 0 equals the horizontal retrace input, and status bit 7 equals the inverse of the vertical retrace input, both as sampled on the previous rising edge.
- R9: Status bit 3 is 1 exactly when status bit 7 is 1 and status bit 0 is 0.
- R10: Status bits 6:4 read 111, bit 1 reads 1 and bit 2 reads 0 at all times.
- R11: Without a mode write strobe the mode byte holds its value, even while configuration writes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| modeWrEn | input | 1 | Single-cycle mode byte write strobe |
| cfgWrEn | input | 1 | Single-cycle configuration byte write strobe |
| wrData | input | 8 | Write data for either register |
| hRetrace | input | 1 | Horizontal retrace from the timing generator, active high |
| vRetrace | input | 1 | Vertical retrace from the timing generator, active high |
| modeOut | output | 8 | Stored (effective) mode byte |
| cfgOut | output | 8 | Stored configuration byte |
| gfxMode | output | 1 | Graphics mode selected (mode bit 1) |
| blinkEn | output | 1 | Blink enable (mode bit 5) |
| pageBase | output | 16 | Display base address, 0x0000 or 0x8000 |
| statusOut | output | 8 | Status byte |

## Verification
The mode register is swept with all 256 write values under eight configuration values. The configuration values are the four enable combinations and the same four with the upper bits set, which shows that only bits 1:0 gate anything. Each value is written twice: once from a state with both protected bits cleared, which shows whether setting is gated, and once from a state with both bits set, which shows that clearing is never blocked. A write of configuration and mode in the same cycle shows that gating uses the configuration value held before the edge. All four combinations of the retrace inputs are applied, which separates the sync polarity, the derived activity bit and the fixed identity bits.

// File: rtl/mono_mode_pkg.sv
package mono_mode_pkg;
  localparam int DATA_W = 8;
  localparam int PROT_N = 2;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic modeLoad;
    logic cfgLoad;
    logic [PROT_N-1:0] setOk;
  } mdaStrobe_t;

  // Mode bit guarded by protection slot i
  function automatic int protPos(input int i);
    return (i == 0) ? 1 : 7;
  endfunction

  // Configuration bit enabling protection slot i
  function automatic int enPos(input int i);
    return i;
  endfunction

  function automatic logic [DATA_W-1:0] protMask();
    logic [DATA_W-1:0] m;
    m = '0;
    for (int i = 0; i < PROT_N; i++) m[protPos(i)] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/mono_mode_ctrl.sv
module mono_mode_ctrl
  import mono_mode_pkg::*;
(
  input  logic              modeWrEn,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] cfgQ,
  output mdaStrobe_t        strb
);
  always_comb begin
    strb.modeLoad = modeWrEn;
    strb.cfgLoad  = cfgWrEn;
  end

  for (genvar i = 0; i < PROT_N; i++) begin : g_en
    assign strb.setOk[i] = cfgQ[enPos(i)];
  end
endmodule

// File: rtl/mono_mode_dp.sv
module mono_mode_dp
  import mono_mode_pkg::*;
#(
  parameter logic [DATA_W-1:0] MODE_RST = 8'h0A,
  parameter logic [DATA_W-1:0] ID_BASE  = 8'h72,
  parameter int ADDR_W      = 16,
  parameter int PAGE_OFFSET = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  mdaStrobe_t        strb,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hRetrace,
  input  logic              vRetrace,
  output logic [DATA_W-1:0] modeQ,
  output logic [DATA_W-1:0] cfgQ,
  output logic [ADDR_W-1:0] pageBase,
  output logic [DATA_W-1:0] statusOut
);
  localparam logic [DATA_W-1:0] PMASK = protMask();
  localparam logic [ADDR_W-1:0] PAGE_HI = ADDR_W'(PAGE_OFFSET);

  logic [DATA_W-1:0] protNext;
  logic [DATA_W-1:0] modeNext;
  logic hsQ, vsQ;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    if (PMASK[b]) begin : g_prot
      int slot;
      always_comb begin
        slot = 0;
        for (int i = 0; i < PROT_N; i++)
          if (protPos(i) == b) slot = i;
      end
      assign protNext[b] = wrData[b] & (modeQ[b] | strb.setOk[slot]);
    end else begin : g_free
      assign protNext[b] = 1'b0;
    end
  end

  always_comb begin
    modeNext = modeQ;
    if (strb.modeLoad) modeNext = (wrData & ~PMASK) | (protNext & PMASK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeQ <= MODE_RST;
      cfgQ  <= '0;
      hsQ   <= 1'b0;
      vsQ   <= 1'b0;
    end else begin
      modeQ <= modeNext;
      if (strb.cfgLoad) cfgQ <= wrData;
      hsQ <= hRetrace;
      vsQ <= vRetrace;
    end
  end

  always_comb begin
    pageBase  = modeQ[protPos(1)] ? PAGE_HI : '0;
    statusOut = ID_BASE;
    statusOut[0] = hsQ;
    statusOut[7] = ~vsQ;
    statusOut[3] = ~vsQ & ~hsQ;
  end
endmodule

// File: rtl/mono_mode_status.sv
module mono_mode_status
  import mono_mode_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int PAGE_OFFSET = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeWrEn,
  input  logic              cfgWrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              hRetrace,
  input  logic              vRetrace,
  output logic [DATA_W-1:0] modeOut,
  output logic [DATA_W-1:0] cfgOut,
  output logic              gfxMode,
  output logic              blinkEn,
  output logic [ADDR_W-1:0] pageBase,
  output logic [DATA_W-1:0] statusOut
);
  mdaStrobe_t strb;

  mono_mode_ctrl u_ctrl (
    .modeWrEn(modeWrEn),
    .cfgWrEn (cfgWrEn),
    .cfgQ    (cfgOut),
    .strb    (strb)
  );

  mono_mode_dp #(
    .ADDR_W     (ADDR_W),
    .PAGE_OFFSET(PAGE_OFFSET)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .wrData   (wrData),
    .hRetrace (hRetrace),
    .vRetrace (vRetrace),
    .modeQ    (modeOut),
    .cfgQ     (cfgOut),
    .pageBase (pageBase),
    .statusOut(statusOut)
  );

  assign gfxMode = modeOut[1];
  assign blinkEn = modeOut[5];
endmodule

// File: rtl/mono_mode_status_chk.sv
module mono_mode_status_chk (
  input logic        clk,
  input logic        rstN,
  input logic        modeWrEn,
  input logic        cfgWrEn,
  input logic [7:0]  wrData,
  input logic        hRetrace,
  input logic        vRetrace,
  input logic [7:0]  modeOut,
  input logic [7:0]  cfgOut,
  input logic        blinkEn,
  input logic [15:0] pageBase,
  input logic [7:0]  statusOut
);
  // R2
  gfx_set_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeOut[1]) |-> $past(cfgOut[0]));
  // R4
  page_set_gated_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(modeOut[7]) |-> $past(cfgOut[1]));
  // R3
  prot_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modeWrEn && !wrData[1] && !wrData[7]) |=> (!modeOut[1] && !modeOut[7]));
  // R5
  free_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    modeWrEn |=> ((modeOut & 8'h7D) == ($past(wrData) & 8'h7D)) && (blinkEn == $past(wrData[5])));
  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !modeWrEn |=> $stable(modeOut));
  // R7
  cfg_store_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> cfgOut == $past(wrData));
  // R6
  page_base_chk: assert property (@(posedge clk) disable iff (!rstN)
    pageBase == (modeOut[7] ? 16'h8000 : 16'h0000));
  // R8
  sync_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rstN) |-> (statusOut[0] == $past(hRetrace)) && (statusOut[7] == !$past(vRetrace)));
  // R9
  activity_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    statusOut[3] == (statusOut[7] && !statusOut[0]));
  // R10
  ident_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (statusOut[6:4] == 3'b111) && statusOut[1] && !statusOut[2]);
endmodule

bind mono_mode_status mono_mode_status_chk u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .modeWrEn (modeWrEn),
  .cfgWrEn  (cfgWrEn),
  .wrData   (wrData),
  .hRetrace (hRetrace),
  .vRetrace (vRetrace),
  .modeOut  (modeOut),
  .cfgOut   (cfgOut),
  .blinkEn  (blinkEn),
  .pageBase (pageBase),
  .statusOut(statusOut)
);

// File: tb/mono_mode_status_tb.sv
module mono_mode_status_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic modeWrEn = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic hRetrace = 1'b0;
  logic vRetrace = 1'b0;
  logic [7:0] modeOut, cfgOut, statusOut;
  logic gfxMode, blinkEn;
  logic [15:0] pageBase;

  int total = 0;
  int bad = 0;
  logic [7:0] expMode;
  logic [7:0] expCfg;

  always #(CLK_PERIOD/2) clk = ~clk;

  mono_mode_status u_dut (
    .clk(clk), .rstN(rstN), .modeWrEn(modeWrEn), .cfgWrEn(cfgWrEn),
    .wrData(wrData), .hRetrace(hRetrace), .vRetrace(vRetrace),
    .modeOut(modeOut), .cfgOut(cfgOut), .gfxMode(gfxMode), .blinkEn(blinkEn),
    .pageBase(pageBase), .statusOut(statusOut)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] nextMode(input logic [7:0] cur, input logic [7:0] cfg,
                                          input logic [7:0] d);
    logic [7:0] r;
    r = d & 8'h7D;
    r[1] = d[1] & (cur[1] | cfg[0]);
    r[7] = d[7] & (cur[7] | cfg[1]);
    return r;
  endfunction

  task automatic writeRegs(input logic doMode, input logic doCfg, input logic [7:0] d);
    @(negedge clk);
    modeWrEn = doMode;
    cfgWrEn = doCfg;
    wrData = d;
    @(negedge clk);
    modeWrEn = 1'b0;
    cfgWrEn = 1'b0;
    if (doMode) expMode = nextMode(expMode, expCfg, d);
    if (doCfg) expCfg = d;
  endtask

  task automatic checkMode(input string tag);
    check(tag, modeOut, expMode);
    check("R5 blink", blinkEn, expMode[5]);
    check("R2 gfxMode", gfxMode, expMode[1]);
    check("R6 pageBase", pageBase, expMode[7] ? 16'h8000 : 16'h0000);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] cfgSet [8];
    cfgSet = '{8'h00, 8'h01, 8'h02, 8'h03, 8'hFC, 8'hFD, 8'hFE, 8'hFF};

    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 mode in reset", modeOut, 8'h0A);
    check("R1 cfg in reset", cfgOut, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    @(negedge clk);
    expMode = 8'h0A;
    expCfg = 8'h00;
    check("R1 mode after reset", modeOut, 8'h0A);
    check("R1 cfg after reset", cfgOut, 8'h00);
    check("R1 blink after reset", blinkEn, 1'b0);
    check("R1 page after reset", pageBase, 16'h0000);

    // R11: a configuration write leaves the mode byte alone
    writeRegs(1'b0, 1'b1, 8'h5A);
    check("R7 cfg readback", cfgOut, 8'h5A);
    check("R11 mode hold", modeOut, 8'h0A);

    // R2/R3/R4/R5/R7 sweep
    foreach (cfgSet[k]) begin
      for (int d = 0; d < 256; d++) begin
        // Path A: protected bits cleared first, then gated set attempt
        writeRegs(1'b1, 1'b0, 8'h00);
        check("R3 clear", modeOut & 8'h82, 8'h00);
        writeRegs(1'b0, 1'b1, cfgSet[k]);
        check("R7 cfg", cfgOut, cfgSet[k]);
        writeRegs(1'b1, 1'b0, 8'(d));
        checkMode("R2 R4 gated set");
        // Path B: both protected bits set, then any write
        writeRegs(1'b0, 1'b1, 8'h03);
        writeRegs(1'b1, 1'b0, 8'h82);
        check("R4 set enabled", modeOut, 8'h82);
        writeRegs(1'b0, 1'b1, cfgSet[k]);
        writeRegs(1'b1, 1'b0, 8'(d));
        checkMode("R3 R5 from set");
      end
    end

    // R2: same-cycle cfg and mode write uses the old cfg
    writeRegs(1'b0, 1'b1, 8'h00);
    writeRegs(1'b1, 1'b0, 8'h00);
    writeRegs(1'b1, 1'b1, 8'h83);
    check("R2 old cfg gates", modeOut, 8'h01);
    check("R7 cfg same cycle", cfgOut, 8'h83);

    // R8/R9/R10 status sweep
    for (int s = 0; s < 4; s++) begin
      logic [7:0] expSt;
      @(negedge clk);
      hRetrace = s[0];
      vRetrace = s[1];
      @(negedge clk);
      expSt = 8'h72;
      expSt[0] = s[0];
      expSt[7] = ~s[1];
      expSt[3] = ~s[1] & ~s[0];
      check("R8 R9 R10 status", statusOut, expSt);
      check("R10 ident", statusOut & 8'h76, 8'h72);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule